// File: doc/BRIEF.md
# Device Access SMI Trap Latches

This block arms a system-management interrupt for each of three monitored peripheral classes: parallel I/O, the floppy drive and the hard drive. The device decoders outside the block raise a one-cycle access strobe for each class. A strobe triggers a trap only when the device is armed and software has enabled trapping for it. A trap moves the device into its trapped state and sets its latch bit. That bit records which device caused the interrupt and masks any further traps from the same device.

Software reaches two 8-bit registers through an indexed configuration port. The latch register sits at index 40h and the enable register at index 41h. Software re-arms a device only by writing 0 to its latch bit; writing 1 leaves the bit as it is. The SMI request is a level. It stays high while any trapped device is also enabled, and it drops once software has cleared every such latch.

Each device is a two-state machine. DEV_ARMED moves to DEV_TRAPPED on the TRAP transition, which needs strobe and enable together. DEV_TRAPPED returns to DEV_ARMED on the REARM transition, which is a latch-register write carrying 0 in that device's bit. Every other case is a HOLD transition that keeps the current state.

Top module: `smi_trap_unit`

## Requirements
- R1: Index 40h reads {5'b0, parallel, floppy, hard}, with the latch bits in positions 2, 1 and 0. Bits 7..3 read 0 and ignore writes.
- R2: Index 41h is an 8-bit read/write enable register that resets to 00h. Enable bits 2, 1 and 0 gate parallel, floppy and hard. Any other index reads 00h.
- R3: After reset every device is in DEV_ARMED, all latch bits read 0 and smi_req is 0.
- R4: When a device's strobe arrives while it is armed and its enable bit is 1, its latch bit reads 1 from the next clock edge on.
- R5: A strobe on a device whose enable bit is 0 leaves its latch bit at 0.
- R6: While a latch bit is 1, further strobes from that device have no effect. Once software clears the bit, no trap is left pending.
- R7: Writing 0 to a latch bit clears it and re-arms the device. Writing 1 to a latch bit leaves it unchanged.
- R8: smi_req is 1 exactly when some latch bit is 1 and its enable bit is 1.
- R9: Strobes that arrive together set the latch bits of all armed and enabled devices in the same edge.
- R10: A trap in the same cycle as a latch-register write of 0 to that bit wins, so the bit becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_index | input | 8 | Configuration register index |
| cfg_wr | input | 1 | Write strobe for the indexed register |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for cfg_index (combinational) |
| acc_strobe | input | 3 | Access strobes: bit 2 parallel, bit 1 floppy, bit 0 hard |
| smi_req | output | 1 | SMI request level |

## Verification
On every cycle the assertions check the per-device transitions: TRAP into DEV_TRAPPED, HOLD while trapped or when nothing triggers, and REARM on a clear. They also check that smi_req rises only after a strobe or an enable write. The bench sweeps every enable mask against every strobe pattern, which shows the register view, the enable gating and the simultaneous setting of latches. Write-1 immunity, reserved bits, unmapped indexes and the priority of a trap over a clear are visible only through the bench's directed scenarios.

// File: rtl/smi_trap_pkg.sv
package smi_trap_pkg;
    localparam int NUM_DEV   = 3;
    localparam int REG_W     = 8;
    localparam int IDX_W     = 8;
    localparam logic [IDX_W-1:0] IDX_LATCH  = 8'h40;
    localparam logic [IDX_W-1:0] IDX_ENABLE = 8'h41;

    typedef enum logic {
        DEV_ARMED   = 1'b0,
        DEV_TRAPPED = 1'b1
    } dev_state_t;
endpackage

// File: rtl/smi_trap_cell.sv
module smi_trap_cell
    import smi_trap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    input  logic enable_i,
    input  logic clear_i,
    output logic trapped_o
);
    dev_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DEV_ARMED;
        else        state_q <= state_d;
    end

    // next-state logic: TRAP beats a clear written in the same cycle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DEV_ARMED:   if (strobe_i && enable_i) state_d = DEV_TRAPPED;
            DEV_TRAPPED: if (clear_i)              state_d = DEV_ARMED;
        endcase
    end

    // outputs
    always_comb begin
        trapped_o = (state_q == DEV_TRAPPED);
    end

    assert_trap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DEV_ARMED && strobe_i && enable_i) |=> trapped_o);
    assert_no_trap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!trapped_o && !(strobe_i && enable_i)) |=> !trapped_o);
    assert_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (trapped_o && !clear_i) |=> trapped_o);
    assert_rearm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (trapped_o && clear_i) |=> !trapped_o);
endmodule

// File: rtl/smi_cfg_regs.sv
module smi_cfg_regs
    import smi_trap_pkg::*;
#(
    parameter int N_DEV = NUM_DEV,
    parameter int DW    = REG_W,
    parameter int IW    = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] cfg_index,
    input  logic          cfg_wr,
    input  logic [DW-1:0] cfg_wdata,
    input  logic [N_DEV-1:0] latch_i,
    output logic [N_DEV-1:0] clear_o,
    output logic [DW-1:0] enable_o,
    output logic [DW-1:0] cfg_rdata
);
    localparam int RSV_W = DW - N_DEV;

    logic [DW-1:0] enable_q;
    logic          wr_latch, wr_enable;

    always_comb begin
        wr_latch  = cfg_wr && (cfg_index == IW'(IDX_LATCH));
        wr_enable = cfg_wr && (cfg_index == IW'(IDX_ENABLE));
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         enable_q <= '0;
        else if (wr_enable) enable_q <= cfg_wdata;
    end

    genvar g;
    generate
        for (g = 0; g < N_DEV; g++) begin : g_clr
            assign clear_o[g] = wr_latch && !cfg_wdata[g];
        end
    endgenerate

    always_comb begin
        if (cfg_index == IW'(IDX_LATCH))       cfg_rdata = {{RSV_W{1'b0}}, latch_i};
        else if (cfg_index == IW'(IDX_ENABLE)) cfg_rdata = enable_q;
        else                                   cfg_rdata = '0;
    end

    assign enable_o = enable_q;

    assert_enable_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_enable |=> $stable(enable_q));
endmodule

// File: rtl/smi_trap_unit.sv
module smi_trap_unit
    import smi_trap_pkg::*;
#(
    parameter int N_DEV = NUM_DEV,
    parameter int DW    = REG_W,
    parameter int IW    = IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IW-1:0]    cfg_index,
    input  logic             cfg_wr,
    input  logic [DW-1:0]    cfg_wdata,
    output logic [DW-1:0]    cfg_rdata,
    input  logic [N_DEV-1:0] acc_strobe,
    output logic             smi_req
);
    logic [N_DEV-1:0] latch, clear;
    logic [DW-1:0]    enable;

    smi_cfg_regs #(.N_DEV(N_DEV), .DW(DW), .IW(IW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_index (cfg_index),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .latch_i   (latch),
        .clear_o   (clear),
        .enable_o  (enable),
        .cfg_rdata (cfg_rdata)
    );

    genvar g;
    generate
        for (g = 0; g < N_DEV; g++) begin : g_dev
            smi_trap_cell u_cell (
                .clk       (clk),
                .rst_n     (rst_n),
                .strobe_i  (acc_strobe[g]),
                .enable_i  (enable[g]),
                .clear_i   (clear[g]),
                .trapped_o (latch[g])
            );
        end
    endgenerate

    always_comb begin
        smi_req = |(latch & enable[N_DEV-1:0]);
    end

    assert_smi_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(smi_req) |-> ($past(|acc_strobe) ||
                            $past(cfg_wr && cfg_index == IW'(IDX_ENABLE))));
endmodule

// File: tb/smi_trap_unit_tb.sv
module smi_trap_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] cfg_index;
    logic       cfg_wr;
    logic [7:0] cfg_wdata;
    logic [7:0] cfg_rdata;
    logic [2:0] acc_strobe;
    logic       smi_req;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    smi_trap_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_index(cfg_index), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .acc_strobe(acc_strobe), .smi_req(smi_req)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] idx, input logic [7:0] data);
        @(negedge clk);
        cfg_index = idx; cfg_wdata = data; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic strobe(input logic [2:0] s);
        @(negedge clk);
        acc_strobe = s;
        @(negedge clk);
        acc_strobe = '0;
    endtask

    task automatic rd(input string req, input logic [7:0] idx, input logic [7:0] exp);
        cfg_index = idx;
        #1;
        check(req, cfg_rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_index = 8'h00; cfg_wr = 1'b0; cfg_wdata = '0; acc_strobe = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R3 reset state
        rd("R3", 8'h40, 8'h00);
        check("R3", {7'b0, smi_req}, 8'h00);
        rd("R2", 8'h41, 8'h00);

        // R4 R5 R8 R9 sweep: every enable mask against every strobe pattern
        for (int en = 0; en < 8; en++) begin
            for (int s = 0; s < 8; s++) begin
                wr(8'h41, 8'h00);
                wr(8'h40, 8'h00);
                wr(8'h41, 8'(en));
                strobe(3'(s));
                rd("R4_R5_R9", 8'h40, 8'(s & en));
                check("R8", {7'b0, smi_req}, {7'b0, |(s & en)});
            end
        end

        // R1 write of ones keeps reserved bits 0; R7 write 1 has no effect
        wr(8'h41, 8'h07);
        wr(8'h40, 8'h00);
        strobe(3'b010);
        wr(8'h40, 8'hFF);
        rd("R1_R7", 8'h40, 8'h02);
        check("R7", {7'b0, smi_req}, 8'h01);

        // R6 masked while trapped, nothing pending after clear
        strobe(3'b010);
        rd("R6", 8'h40, 8'h02);
        wr(8'h40, 8'hFD);
        rd("R7", 8'h40, 8'h00);
        check("R6", {7'b0, smi_req}, 8'h00);
        @(negedge clk);
        rd("R6", 8'h40, 8'h00);

        // R8 level follows enable with latch held
        strobe(3'b100);
        wr(8'h41, 8'h03);
        check("R8", {7'b0, smi_req}, 8'h00);
        rd("R8", 8'h40, 8'h04);
        wr(8'h41, 8'h07);
        check("R8", {7'b0, smi_req}, 8'h01);
        wr(8'h40, 8'h00);

        // R10 trap coincides with a clear write of that bit
        @(negedge clk);
        cfg_index = 8'h40; cfg_wdata = 8'h00; cfg_wr = 1'b1; acc_strobe = 3'b001;
        @(negedge clk);
        cfg_wr = 1'b0; acc_strobe = '0;
        rd("R10", 8'h40, 8'h01);

        // R2 full-width enable readback, unmapped indexes
        wr(8'h41, 8'hA5);
        rd("R2", 8'h41, 8'hA5);
        wr(8'h42, 8'hFF);
        rd("R2", 8'h42, 8'h00);
        rd("R2", 8'h3F, 8'h00);
        rd("R2", 8'h41, 8'hA5);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule